// File: doc/BRIEF.md
# Sub-Word Register Access Front-End

This block connects a control-register request bus to a bank of 64-bit registers that only understands whole-word operations. A requester may read or write 1, 2, 4 or 8 bytes at a time. The block checks that the address is a multiple of the access length. It then finds which register range the address falls in and which word of that range is meant. Every narrow access becomes one full-word operation on the bank.

On a write, the bytes of the request are placed into their lanes and merged into the current word under a byte-lane mask. The bank receives the range number, the word index, the merged value, the bit mask of the lanes that change and the value the word held before the write. With the last two, the bank's own side-effect logic can act on exactly the bits that were touched. On a read, the word is shifted down to the addressed bytes and a narrow result is sign-extended to 64 bits. Every request gets a response one cycle later. The response carries an error flag, and its read data is zero whenever it is not a successful read.

Top module: `subword_access_frontend`

## Requirements
- R1: An access whose address is not a multiple of its length (size code 0/1/2/3 = 1/2/4/8 bytes) is answered with `rsp_err` = 1 and zero read data. A write of this kind raises no bank write.
- R2: An access whose word address lies in no register range is answered with `rsp_err` = 1 and zero read data. A write of this kind raises no bank write.
- R3: With the default map, range 0 starts at 0x0100 and has 4 words, range 1 starts at 0x0200 and has 8 words, and range 2 starts at 0x0400 and has 32 words. The word address is the request address with its low 3 bits cleared. `bank_sel` gives the number of the range that holds it, and `bank_idx` gives (word address − range start) / 8.
- R4: For a mapped, aligned write, `bank_wr_mask` is all ones over the bytes from offset addr[2:0] up to offset + length − 1, and zero elsewhere.
- R5: The merged word keeps every old bit outside the mask. Inside the mask it holds the low `length` bytes of `req_wdata`, moved up by the byte offset. Bytes of `req_wdata` at and above the access length have no effect.
- R6: A 1-, 2- or 4-byte read returns the addressed bytes in the low bits of `rsp_rdata`, sign-extended from bit 7, 15 or 31 respectively.
- R7: An 8-byte read returns the whole addressed word unchanged.
- R8: `rsp_valid` is high in exactly the cycle after each cycle with `req_valid` high, and low otherwise. A write's response has zero read data.
- R9: During a mapped, aligned write, `bank_wr_en` is high and `bank_wr_old` equals the word's value before the write. The written value is the one later read back.
- R10: After reset, `rsp_valid`, `rsp_err` and `rsp_rdata` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W (16) | Byte address |
| req_size | input | 2 | Access length code: 0=1, 1=2, 2=4, 3=8 bytes |
| req_wdata | input | DATA_W (64) | Write data, right-aligned |
| rsp_valid | output | 1 | Response present |
| rsp_err | output | 1 | Misaligned or unmapped access |
| rsp_rdata | output | DATA_W (64) | Shifted, sign-extended read data |
| bank_sel | output | SEL_W (2) | Range number of the addressed word |
| bank_idx | output | IDX_W (5) | Word index within the range |
| bank_rd_data | input | DATA_W (64) | Current word value from the bank, same cycle |
| bank_wr_en | output | 1 | Write the merged word this cycle |
| bank_wr_data | output | DATA_W (64) | Merged word |
| bank_wr_mask | output | DATA_W (64) | Bits that the write replaces |
| bank_wr_old | output | DATA_W (64) | Word value before the merge |

## Verification
Suppose the byte offset or the lane mask is computed wrongly. A later 8-byte read-back would then show neighbouring bytes overwritten or left unchanged, so the fault shows up at the ports one access later. The bank write outputs also show it in the request cycle itself. A wrong range decode shows up in the same cycle as a wrong `bank_sel` or `bank_idx`, or one cycle later as a false error flag on a boundary address. A fault in the sign extension or the response register shows up in the response cycle as wrong upper bits of `rsp_rdata`, or as `rsp_valid` arriving at the wrong time.

// File: rtl/swa_pkg.sv
package swa_pkg;
   typedef enum logic [1:0] {
      SZ_BYTE  = 2'd0,
      SZ_HALF  = 2'd1,
      SZ_WORD  = 2'd2,
      SZ_DWORD = 2'd3
   } acc_size_e;

   localparam int CNT_W = 16;
endpackage

// File: rtl/swa_align_check.sv
module swa_align_check #(
   parameter int ADDR_W = 16,
   parameter int OFF_W  = 3,
   parameter int MAX_SZ = 3
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [1:0]        size,
   output logic [OFF_W-1:0]  offset,
   output logic [ADDR_W-1:0] word_addr,
   output logic              aligned
);
   logic [OFF_W:0]   len;
   logic [OFF_W:0]   len_m1;
   logic             size_ok;

   assign offset    = addr[OFF_W-1:0];
   assign word_addr = {addr[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
   assign len       = (OFF_W+1)'(1) << size;
   assign len_m1    = len - (OFF_W+1)'(1);
   assign size_ok   = (32'(size) <= MAX_SZ);
   assign aligned   = size_ok && ((offset & len_m1[OFF_W-1:0]) == '0);
endmodule

// File: rtl/swa_range_decode.sv
module swa_range_decode #(
   parameter int ADDR_W = 16,
   parameter int OFF_W  = 3,
   parameter int NRANGE = 3,
   parameter int IDX_W  = 5,
   parameter int SEL_W  = 2,
   parameter int CNT_W  = 16,
   parameter logic [NRANGE*ADDR_W-1:0] RANGE_BASE  = '0,
   parameter logic [NRANGE*CNT_W-1:0]  RANGE_WORDS = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] word_addr,
   output logic              hit,
   output logic [SEL_W-1:0]  sel,
   output logic [IDX_W-1:0]  idx
);
   localparam int EXT_W = ADDR_W + CNT_W + OFF_W + 1;

   logic [NRANGE-1:0] hit_vec;
   logic [IDX_W-1:0]  idx_vec [NRANGE];

   for (genvar i = 0; i < NRANGE; i++) begin : g_rng
      localparam logic [ADDR_W-1:0] BASE  = RANGE_BASE[i*ADDR_W +: ADDR_W];
      localparam logic [CNT_W-1:0]  WORDS = RANGE_WORDS[i*CNT_W +: CNT_W];
      localparam logic [EXT_W-1:0]  LIM   = EXT_W'(BASE) + (EXT_W'(WORDS) << OFF_W);

      if (BASE[OFF_W-1:0] != '0) begin : g_bad_base
         $error("range base must be word aligned");
      end
      if (WORDS == '0 || 32'(WORDS) > (1 << IDX_W)) begin : g_bad_words
         $error("range word count must be 1 .. 2**IDX_W");
      end
      for (genvar j = i + 1; j < NRANGE; j++) begin : g_pair
         localparam longint BI = longint'(BASE);
         localparam longint BJ = longint'(RANGE_BASE[j*ADDR_W +: ADDR_W]);
         localparam longint EI = BI + 8 * longint'(WORDS);
         localparam longint EJ = BJ + 8 * longint'(RANGE_WORDS[j*CNT_W +: CNT_W]);
         if (BI < EJ && BJ < EI) begin : g_overlap
            $error("register ranges overlap");
         end
      end

      logic [ADDR_W-1:0] rel;
      assign rel        = word_addr - BASE;
      assign hit_vec[i] = (EXT_W'(word_addr) >= EXT_W'(BASE)) &&
                          (EXT_W'(word_addr) <  LIM);
      assign idx_vec[i] = IDX_W'(rel >> OFF_W);
   end

   always_comb begin
      sel = '0;
      idx = '0;
      for (int i = NRANGE - 1; i >= 0; i--) begin
         if (hit_vec[i]) begin
            sel = SEL_W'(i);
            idx = idx_vec[i];
         end
      end
   end

   assign hit = |hit_vec;

   // R2: ranges are disjoint, so at most one range can claim an address
   a_r2_single_hit: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(hit_vec));
endmodule

// File: rtl/swa_lane_merge.sv
module swa_lane_merge #(
   parameter int DATA_W = 64,
   parameter int LANES  = DATA_W / 8,
   parameter int OFF_W  = $clog2(LANES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              chk_en,
   input  logic [1:0]        size,
   input  logic [OFF_W-1:0]  offset,
   input  logic [DATA_W-1:0] wdata,
   input  logic [DATA_W-1:0] old,
   output logic [DATA_W-1:0] mask,
   output logic [DATA_W-1:0] merged
);
   logic [LANES-1:0]  field_lanes;
   logic [LANES-1:0]  lane_en;
   logic [DATA_W-1:0] field_bits;
   logic [DATA_W-1:0] data_sh;

   for (genvar l = 0; l < LANES; l++) begin : g_lane
      assign field_lanes[l]      = (32'(l) < (32'd1 << size));
      assign field_bits[8*l +: 8] = {8{field_lanes[l]}};
      assign mask[8*l +: 8]       = {8{lane_en[l]}};
   end

   assign lane_en = field_lanes << offset;
   assign data_sh = (wdata & field_bits) << {offset, 3'b000};
   assign merged  = (old & ~mask) | data_sh;

   // R4: an aligned access changes exactly as many lanes as its length
   a_r4_lane_count: assert property (@(posedge clk) disable iff (!rst_n)
      chk_en |-> ($countones(lane_en) == (32'd1 << size)));
endmodule

// File: rtl/swa_read_extract.sv
module swa_read_extract #(
   parameter int DATA_W = 64,
   parameter int LANES  = DATA_W / 8,
   parameter int OFF_W  = $clog2(LANES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              chk_en,
   input  logic [1:0]        size,
   input  logic [OFF_W-1:0]  offset,
   input  logic [DATA_W-1:0] word,
   output logic [DATA_W-1:0] result
);
   logic [DATA_W-1:0] shifted;
   logic [DATA_W-1:0] ext [OFF_W+1];

   assign shifted = word >> {offset, 3'b000};

   for (genvar k = 0; k < OFF_W; k++) begin : g_ext
      localparam int FW = 8 << k;
      assign ext[k] = {{(DATA_W-FW){shifted[FW-1]}}, shifted[FW-1:0]};
   end
   assign ext[OFF_W] = shifted;

   always_comb begin
      result = '0;
      for (int k = 0; k <= OFF_W; k++) begin
         if (32'(size) == k) result = ext[k];
      end
   end

   // R6: a byte read fills every upper bit with the byte's top bit
   a_r6_byte_sign_fill: assert property (@(posedge clk) disable iff (!rst_n)
      (chk_en && size == 2'd0) |-> (result[DATA_W-1:8] == {(DATA_W-8){word[8*offset+7]}}));
endmodule

// File: rtl/subword_access_frontend.sv
module subword_access_frontend
   import swa_pkg::*;
#(
   parameter int ADDR_W = 16,
   parameter int DATA_W = 64,
   parameter int NRANGE = 3,
   parameter int IDX_W  = 5,
   parameter logic [NRANGE*ADDR_W-1:0] RANGE_BASE  = {16'h0400, 16'h0200, 16'h0100},
   parameter logic [NRANGE*CNT_W-1:0]  RANGE_WORDS = {16'd32, 16'd8, 16'd4},
   localparam int SEL_W = (NRANGE > 1) ? $clog2(NRANGE) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_write,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [1:0]        req_size,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              rsp_valid,
   output logic              rsp_err,
   output logic [DATA_W-1:0] rsp_rdata,
   output logic [SEL_W-1:0]  bank_sel,
   output logic [IDX_W-1:0]  bank_idx,
   input  logic [DATA_W-1:0] bank_rd_data,
   output logic              bank_wr_en,
   output logic [DATA_W-1:0] bank_wr_data,
   output logic [DATA_W-1:0] bank_wr_mask,
   output logic [DATA_W-1:0] bank_wr_old
);
   localparam int LANES  = DATA_W / 8;
   localparam int OFF_W  = $clog2(LANES);
   localparam int MAX_SZ = OFF_W;

   if (DATA_W != 32 && DATA_W != 64) begin : g_bad_width
      $error("DATA_W must be 32 or 64");
   end
   if (ADDR_W <= OFF_W) begin : g_bad_addr
      $error("ADDR_W too small");
   end

   logic [OFF_W-1:0]  offset;
   logic [ADDR_W-1:0] word_addr;
   logic              aligned;
   logic              hit;
   logic              acc_ok;
   logic [DATA_W-1:0] rd_ext;

   swa_align_check #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .MAX_SZ(MAX_SZ)) u_align (
      .addr(req_addr), .size(req_size), .offset(offset),
      .word_addr(word_addr), .aligned(aligned));

   swa_range_decode #(
      .ADDR_W(ADDR_W), .OFF_W(OFF_W), .NRANGE(NRANGE), .IDX_W(IDX_W),
      .SEL_W(SEL_W), .CNT_W(CNT_W), .RANGE_BASE(RANGE_BASE),
      .RANGE_WORDS(RANGE_WORDS)) u_decode (
      .clk(clk), .rst_n(rst_n), .word_addr(word_addr),
      .hit(hit), .sel(bank_sel), .idx(bank_idx));

   assign acc_ok = req_valid && aligned && hit;

   swa_lane_merge #(.DATA_W(DATA_W)) u_merge (
      .clk(clk), .rst_n(rst_n), .chk_en(req_valid && aligned),
      .size(req_size), .offset(offset), .wdata(req_wdata),
      .old(bank_rd_data), .mask(bank_wr_mask), .merged(bank_wr_data));

   swa_read_extract #(.DATA_W(DATA_W)) u_extract (
      .clk(clk), .rst_n(rst_n), .chk_en(req_valid && aligned),
      .size(req_size), .offset(offset), .word(bank_rd_data), .result(rd_ext));

   assign bank_wr_en  = acc_ok && req_write;
   assign bank_wr_old = bank_rd_data;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_err   <= 1'b0;
         rsp_rdata <= '0;
      end else begin
         rsp_valid <= req_valid;
         rsp_err   <= req_valid && !(aligned && hit);
         rsp_rdata <= (acc_ok && !req_write) ? rd_ext : '0;
      end
   end

   // R8: every request is answered in the next cycle
   a_r8_rsp_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> rsp_valid);
   // R8: no response without a request
   a_r8_no_spurious_rsp: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !rsp_valid);
   // R1: a misaligned request gets an error response
   a_r1_misaligned_err: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !aligned) |=> rsp_err);
   // R1, R2: an errored request never wrote the bank
   a_r2_no_write_on_err: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_err |-> !$past(bank_wr_en));
   // R2: error responses carry zero data
   a_r2_err_data_zero: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_err |-> (rsp_rdata == '0));
endmodule

// File: tb/subword_access_frontend_tb.sv
module subword_access_frontend_tb_top;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        req_valid, req_write;
   logic [15:0] req_addr;
   logic [1:0]  req_size;
   logic [63:0] req_wdata;
   logic        rsp_valid, rsp_err;
   logic [63:0] rsp_rdata;
   logic [1:0]  bank_sel;
   logic [4:0]  bank_idx;
   logic [63:0] bank_rd_data;
   logic        bank_wr_en;
   logic [63:0] bank_wr_data, bank_wr_mask, bank_wr_old;

   int checks = 0;
   int errors = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   subword_access_frontend dut_i (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_addr(req_addr), .req_size(req_size), .req_wdata(req_wdata),
      .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
      .bank_sel(bank_sel), .bank_idx(bank_idx), .bank_rd_data(bank_rd_data),
      .bank_wr_en(bank_wr_en), .bank_wr_data(bank_wr_data),
      .bank_wr_mask(bank_wr_mask), .bank_wr_old(bank_wr_old));

   function automatic logic [63:0] seed(int r, int i);
      return 64'h8F1E_2D3C_4B5A_6978 ^ (64'(r) << 52) ^ (64'(i) * 64'h0001_0203_F405_0617);
   endfunction

   // harness register bank seen by the DUT
   logic [63:0] hbank [3][32];
   always @(posedge clk) begin
      if (!rst_n) begin
         for (int r = 0; r < 3; r++)
            for (int i = 0; i < 32; i++) hbank[r][i] <= seed(r, i);
      end else if (bank_wr_en && bank_sel < 2'd3) begin
         hbank[bank_sel][bank_idx] <= bank_wr_data;
      end
   end
   assign bank_rd_data = (bank_sel < 2'd3) ? hbank[bank_sel][bank_idx] : 64'h0;

   // reference model state
   logic [63:0] rmem [3][32];
   int rb [3] = '{'h100, 'h200, 'h400};
   int rw [3] = '{4, 8, 32};

   task automatic chk(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic access(bit wr, logic [15:0] addr, int sz, logic [63:0] wd, string req);
      int len = 1 << sz;
      int off = int'(addr) % 8;
      int wa  = int'(addr) - off;
      int r   = -1;
      int idx = 0;
      bit ok;
      logic [63:0] old = 64'h0, nw, msk = 64'h0, er = 64'h0, v;
      for (int k = 0; k < 3; k++)
         if (wa >= rb[k] && wa < rb[k] + 8 * rw[k]) begin r = k; idx = (wa - rb[k]) / 8; end
      ok = (int'(addr) % len == 0) && (r >= 0);
      if (r >= 0) old = rmem[r][idx];
      nw = old;
      for (int j = 0; j < len; j++) begin
         msk[8*(off+j) +: 8] = 8'hFF;
         nw[8*(off+j) +: 8]  = wd[8*j +: 8];
      end
      v = old >> (8 * off);
      case (sz)
         0: er = 64'(longint'($signed(v[7:0])));
         1: er = 64'(longint'($signed(v[15:0])));
         2: er = 64'(longint'($signed(v[31:0])));
         default: er = v;
      endcase
      if (!ok || wr) er = 64'h0;

      req_valid = 1'b1; req_write = wr; req_addr = addr;
      req_size = 2'(sz); req_wdata = wd;
      #1;
      chk(bank_wr_en == (wr && ok), req, "bank_wr_en", 64'(bank_wr_en), 64'(wr && ok));
      if (wr && ok) begin
         chk(bank_wr_mask == msk, req, "lane mask (R4)", bank_wr_mask, msk);
         chk(bank_wr_old == old, req, "old value (R9)", bank_wr_old, old);
         chk(bank_sel == 2'(r) && bank_idx == 5'(idx), req, "sel/idx (R3)",
             {bank_sel, bank_idx}, {2'(r), 5'(idx)});
      end
      @(posedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      chk(rsp_valid == 1'b1, req, "rsp_valid (R8)", 64'(rsp_valid), 64'd1);
      chk(rsp_err == !ok, req, "rsp_err", 64'(rsp_err), 64'(!ok));
      chk(rsp_rdata == er, req, "rsp_rdata", rsp_rdata, er);
      if (wr && ok) rmem[r][idx] = nw;
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      for (int r = 0; r < 3; r++)
         for (int i = 0; i < 32; i++) rmem[r][i] = seed(r, i);
      rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0;
      req_addr = '0; req_size = '0; req_wdata = '0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk(rsp_valid == 0 && rsp_err == 0 && rsp_rdata == 0, "R10", "reset outputs",
          {rsp_valid, rsp_err, rsp_rdata[61:0]}, 64'h0);
      rst_n = 1'b1;
      @(negedge clk);

      // R7 full-word reads, R3 index decode
      access(0, 16'h0100, 3, 0, "R7");
      access(0, 16'h0218, 3, 0, "R3");
      access(0, 16'h04F8, 3, 0, "R3");
      // R6 narrow reads at several offsets
      access(0, 16'h0100, 0, 0, "R6");
      access(0, 16'h0107, 0, 0, "R6");
      access(0, 16'h0106, 1, 0, "R6");
      access(0, 16'h0202, 1, 0, "R6");
      access(0, 16'h0104, 2, 0, "R6");
      access(0, 16'h0408, 2, 0, "R6");
      // R4/R5 narrow writes with junk above the length, then read back
      access(1, 16'h0205, 0, 64'hDEAD_BEEF_CAFE_F0A5, "R5");
      access(0, 16'h0200, 3, 0, "R5");
      access(1, 16'h010A, 1, 64'h1234_5678_9ABC_8001, "R4");
      access(0, 16'h0108, 3, 0, "R4");
      access(1, 16'h0414, 2, 64'hFFFF_FFFF_8765_4321, "R5");
      access(0, 16'h0410, 3, 0, "R9");
      access(0, 16'h0414, 2, 0, "R6");
      access(1, 16'h0118, 3, 64'h0F0E_0D0C_0B0A_0908, "R9");
      access(0, 16'h0118, 3, 0, "R9");
      access(0, 16'h011F, 0, 0, "R6");
      // R1 misaligned
      access(0, 16'h0101, 1, 0, "R1");
      access(0, 16'h0102, 2, 0, "R1");
      access(1, 16'h0104, 3, 64'hFFFF_FFFF_FFFF_FFFF, "R1");
      access(0, 16'h0100, 3, 0, "R1");
      // R2 unmapped edges
      access(0, 16'h0120, 3, 0, "R2");
      access(0, 16'h00F8, 3, 0, "R2");
      access(1, 16'h0240, 3, 64'h1111_2222_3333_4444, "R2");
      access(0, 16'h0500, 0, 0, "R2");
      access(0, 16'h0238, 3, 0, "R3");
      // R8 idle cycle after a request
      @(posedge clk);
      @(negedge clk);
      chk(rsp_valid == 1'b0, "R8", "rsp_valid idle", 64'(rsp_valid), 64'd0);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule